// File: doc/BRIEF.md
# Packed Lane Compare to Bitmask Unit

This block compares two 64-bit operands lane by lane and condenses the outcome into a short bitmask. Each lane yields one bit. The bits are packed at the bottom of a 64-bit result, and every bit above them is cleared. The lanes can be four 16-bit fields or two 32-bit fields. Four predicates are available: greater-than, equal, less-or-equal and not-equal. All lane values are treated as unsigned integers.

A typical use is in a SIMD datapath. The mask feeds branch decisions, select masks or population counts without a later reduction step. The inputs are captured on a clock edge and the mask is presented from a register one cycle later. That one-cycle stage is the only state in the block.

Top module: `pcmp_mask_unit`

## Requirements
- R1: While `rst_n` is low, `mask_out` is all zeros, whatever the other inputs are.
- R2: Inputs present at a rising clock edge (with `rst_n` high) set `mask_out` from that edge onward. Before that edge the output keeps its previous value.
- R3: With `wide_sel` = 0, the lanes are 16 bits wide and lane i occupies bits [16i+15:16i] of each operand, so lane 0 is the least significant. `mask_out[i]` (i = 0..3) is 1 exactly when the predicate holds for lane i of `opa` against lane i of `opb`.
- R4: With `wide_sel` = 0, `mask_out[63:4]` is zero.
- R5: With `wide_sel` = 1, the lanes are 32 bits wide and lane i occupies bits [32i+31:32i]. `mask_out[0]` and `mask_out[1]` carry the predicate results for lanes 0 and 1.
- R6: With `wide_sel` = 1, `mask_out[63:2]` is zero.
- R7: Lane values are compared as unsigned numbers. For example, 0x8000 is greater than 0x7FFF in a 16-bit lane.
- R8: `pred_sel` selects the predicate, where "a" is the `opa` lane and "b" is the `opb` lane:
  - 2'b00: a > b
  - 2'b01: a == b
  - 2'b10: a <= b
  - 2'b11: a != b
- R9: For the same operands and width, the greater-than mask and the less-or-equal mask are bitwise complements within the active lane bits. The equal mask and the not-equal mask are complements in the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs are captured on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the result register |
| pred_sel | input | 2 | Predicate code (00 gt, 01 eq, 10 le, 11 ne) |
| wide_sel | input | 1 | 0: four 16-bit lanes, 1: two 32-bit lanes |
| opa | input | 64 | First operand (left side of the predicate) |
| opb | input | 64 | Second operand (right side of the predicate) |
| mask_out | output | 64 | Packed per-lane result bits, all upper bits zero |

## Verification
The hardest cases to reach from the ports are those where the lane fields differ only at their edges. Examples are lanes that are equal while their neighbours are not, and values that straddle the unsigned midpoint such as 0x7FFF against 0x8000. Random 64-bit operands almost never produce equal lanes, so the stimulus builds each lane from a small list of edge values. It rotates lane pairings so that every ordered value pair reaches every lane position. Random vectors are then generated with the second operand partly copied lane by lane from the first, which forces mixed equal and unequal lanes. Each vector is run under both widths and all four predicate codes.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

    // Predicate codes as driven on pred_sel
    typedef enum logic [1:0] {
        PRED_GT = 2'b00,
        PRED_EQ = 2'b01,
        PRED_LE = 2'b10,
        PRED_NE = 2'b11
    } pcmp_pred_e;

endpackage

// File: rtl/pcmp_lane_cmp.sv
module pcmp_lane_cmp
    import pcmp_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0] lane_a,
    input  logic [LANE_W-1:0] lane_b,
    input  pcmp_pred_e        pred,
    output logic              hit
);

    logic a_gt;
    logic a_eq;

    // Unsigned magnitude and equality, shared by all four predicates
    always_comb begin
        a_gt = (lane_a > lane_b);
        a_eq = (lane_a == lane_b);
        case (pred)
            PRED_GT: hit = a_gt;
            PRED_EQ: hit = a_eq;
            PRED_LE: hit = ~a_gt;
            PRED_NE: hit = ~a_eq;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcmp_lane_bank.sv
module pcmp_lane_bank
    import pcmp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16
) (
    input  logic [DATA_W-1:0]        opa,
    input  logic [DATA_W-1:0]        opb,
    input  pcmp_pred_e               pred,
    output logic [DATA_W/LANE_W-1:0] hits
);

    localparam int NLANES = DATA_W / LANE_W;

    for (genvar gi = 0; gi < NLANES; gi++) begin : g_lane
        pcmp_lane_cmp #(
            .LANE_W (LANE_W)
        ) u_cmp (
            .lane_a (opa[gi*LANE_W +: LANE_W]),
            .lane_b (opb[gi*LANE_W +: LANE_W]),
            .pred   (pred),
            .hit    (hits[gi])
        );
    end

endmodule

// File: rtl/pcmp_mask_unit.sv
module pcmp_mask_unit
    import pcmp_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pred_sel,
    input  logic              wide_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] mask_out
);

    localparam int N_NARROW = DATA_W / NARROW_W;
    localparam int N_WIDE   = DATA_W / WIDE_W;

    typedef struct packed {
        logic [DATA_W-1:0] mask;
    } mask_state_t;

    mask_state_t st_d;
    mask_state_t st_q;

    pcmp_pred_e             pred;
    logic [N_NARROW-1:0]    hits_narrow;
    logic [N_WIDE-1:0]      hits_wide;

    assign pred = pcmp_pred_e'(pred_sel);

    pcmp_lane_bank #(
        .DATA_W (DATA_W),
        .LANE_W (NARROW_W)
    ) u_bank_narrow (
        .opa  (opa),
        .opb  (opb),
        .pred (pred),
        .hits (hits_narrow)
    );

    pcmp_lane_bank #(
        .DATA_W (DATA_W),
        .LANE_W (WIDE_W)
    ) u_bank_wide (
        .opa  (opa),
        .opb  (opb),
        .pred (pred),
        .hits (hits_wide)
    );

    // Pack the chosen lane hits at the bottom, clear everything above
    always_comb begin
        st_d = '0;
        if (wide_sel) begin
            st_d.mask[N_WIDE-1:0] = hits_wide;
        end else begin
            st_d.mask[N_NARROW-1:0] = hits_narrow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_out = st_q.mask;

    // Set once a capture has happened since reset, so $past is meaningful
    logic chk_armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_armed_q <= 1'b0;
        end else begin
            chk_armed_q <= 1'b1;
        end
    end

    assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed_q && !$past(wide_sel)) |-> (mask_out[DATA_W-1:N_NARROW] == '0));

    assert_wide_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed_q && $past(wide_sel)) |-> (mask_out[DATA_W-1:N_WIDE] == '0));

    assert_eq_all_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed_q && $past(pred_sel) == PRED_EQ && $past(opa) == $past(opb) && !$past(wide_sel))
        |-> (mask_out[N_NARROW-1:0] == '1));

    assert_ne_same_ops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed_q && $past(pred_sel) == PRED_NE && $past(opa) == $past(opb))
        |-> (mask_out == '0));

    assert_gt_same_ops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed_q && $past(pred_sel) == PRED_GT && $past(opa) == $past(opb))
        |-> (mask_out == '0));

    assert_le_same_ops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed_q && $past(pred_sel) == PRED_LE && $past(opa) == $past(opb) && $past(wide_sel))
        |-> (mask_out == DATA_W'((1 << N_WIDE) - 1)));

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (mask_out == '0));

endmodule

// File: tb/pcmp_mask_unit_tb.sv
`timescale 1ns/1ps
module pcmp_mask_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pred_sel = 2'b01;
    logic        wide_sel = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [63:0] mask_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    pcmp_mask_unit u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pred_sel (pred_sel),
        .wide_sel (wide_sel),
        .opa      (opa),
        .opb      (opb),
        .mask_out (mask_out)
    );

    function automatic logic [63:0] model(logic [1:0] p, logic w, logic [63:0] a, logic [63:0] b);
        logic [63:0] r = '0;
        int lw = w ? 32 : 16;
        int n  = w ? 2 : 4;
        for (int i = 0; i < n; i++) begin
            longint unsigned la = (a >> (i * lw)) & ((64'd1 << lw) - 1);
            longint unsigned lb = (b >> (i * lw)) & ((64'd1 << lw) - 1);
            case (p)
                2'b00: r[i] = (la > lb);
                2'b01: r[i] = (la == lb);
                2'b10: r[i] = (la <= lb);
                default: r[i] = (la != lb);
            endcase
        end
        return r;
    endfunction

    function automatic logic [63:0] next_rand(logic [63:0] x);
        logic [63:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, compare one falling edge later
    task automatic apply(string tag, logic [1:0] p, logic w, logic [63:0] a, logic [63:0] b);
        @(negedge clk);
        pred_sel = p;
        wide_sel = w;
        opa = a;
        opb = b;
        @(negedge clk);
        check(tag, mask_out, model(p, w, a, b));
    endtask

    logic [15:0] nv [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                             16'hFFFE, 16'hFFFF, 16'h1234, 16'h1235};
    logic [31:0] wv [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000,
                             32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0001_0000, 32'h0000_FFFF};

    initial begin
        // R1: reset holds the output at zero even with matching operands
        opa = 64'hAAAA_5555_AAAA_5555;
        opb = opa;
        pred_sel = 2'b01;
        repeat (3) @(negedge clk);
        check("R1 reset output", mask_out, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 before first capture", mask_out, 64'h0);

        // R2: output changes only at the capturing edge
        @(negedge clk);
        pred_sel = 2'b00; wide_sel = 1'b0;
        opa = 64'h0005_0005_0005_0005;
        opb = 64'h0001_0001_0001_0001;
        #1;
        check("R2 held before edge", mask_out, model(2'b01, 1'b0, 64'hAAAA_5555_AAAA_5555, 64'hAAAA_5555_AAAA_5555));
        @(negedge clk);
        check("R2 updated after edge", mask_out, 64'hF);

        // R7: unsigned ordering at the midpoint
        apply("R7 narrow 8000 gt 7FFF", 2'b00, 1'b0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_7FFF);
        apply("R7 wide 80000000 gt 7FFFFFFF", 2'b00, 1'b1, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF);

        // R3 R4 R5 R6 R8: every ordered edge-value pair reaches every lane
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 64; k++) begin
                logic [63:0] a = '0;
                logic [63:0] b = '0;
                for (int i = 0; i < 4; i++) begin
                    a[i*16 +: 16] = nv[(k + 3 * i) % 8];
                    b[i*16 +: 16] = nv[(k / 8 + i) % 8];
                end
                apply("R3 R4 R8 narrow sweep", 2'(p), 1'b0, a, b);
            end
            for (int k = 0; k < 64; k++) begin
                logic [63:0] a = '0;
                logic [63:0] b = '0;
                for (int i = 0; i < 2; i++) begin
                    a[i*32 +: 32] = wv[(k + 5 * i) % 8];
                    b[i*32 +: 32] = wv[(k / 8 + i) % 8];
                end
                apply("R5 R6 R8 wide sweep", 2'(p), 1'b1, a, b);
            end
        end

        // Random vectors with partly copied lanes; R9 complements
        for (int k = 0; k < 100; k++) begin
            logic [63:0] a, b, keep, m_gt, m_le, m_eq, m_ne;
            logic w;
            rng = next_rand(rng); a = rng;
            rng = next_rand(rng); b = rng;
            rng = next_rand(rng);
            keep = {{16{rng[3]}}, {16{rng[2]}}, {16{rng[1]}}, {16{rng[0]}}};
            b = (a & keep) | (b & ~keep);
            w = rng[8];
            for (int p = 0; p < 4; p++) begin
                apply(w ? "R5 R6 random" : "R3 R4 random", 2'(p), w, a, b);
                case (p)
                    0: m_gt = mask_out;
                    1: m_eq = mask_out;
                    2: m_le = mask_out;
                    default: m_ne = mask_out;
                endcase
            end
            check("R9 gt le complement", m_gt ^ m_le, w ? 64'h3 : 64'hF);
            check("R9 eq ne complement", m_eq ^ m_ne, w ? 64'h3 : 64'hF);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule